// File: doc/BRIEF.md
# Synchronizable Clock Divider Channel

This block is one channel of a clock-distribution fabric. It runs on the fast distribution clock and divides it by a programmable integer ratio to make a device clock. The device clock appears as a logic level in the fast-clock domain. Ratios of 2 and 20 take a 3000 MHz distribution clock down to 1500 MHz and 150 MHz.

Several channels can be brought into a known phase with a SYNC event. The event is the rising edge of the external SYNC pin XORed with a software polarity bit, taken through a synchronizer. Toggling the polarity bit high and then low therefore gives a SYNC without driving the pin. On a SYNC the divider restarts and holds its output low for a digital delay, then resumes. The delay is the sum of a high count and a low count. A half-step option shifts the device clock by half a distribution-clock cycle. A per-channel disable bit makes the channel ignore SYNC, so a running channel can be protected from later events.

Top module: `sync_clk_div`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is 0.
- R2: For a divide value N of 2 or more, `clk_o` is periodic with period N. The high phase is ceil(N/2) cycles and the low phase is floor(N/2) cycles.
- R3: A SYNC event is a rising edge of `sync_pin_i ^ sync_pol_i` after a two-flop synchronizer. Drive the combined signal high just after rising edge k-1. The divider then acts on rising edge k+2, which is the event edge E. A falling edge of the combined signal causes no event.
- R4: Let D = `dly_hi_i + dly_lo_i`. After an accepted event with N of 2 or more, the output registers 0 on edges E through E+D-1. It registers 1 on edge E+D, which is the first cycle of a high phase. The R2 pattern then follows.
- R5: The delay depends only on the sum of the high and low counts. Swapping the two counts gives the same phase. A sum of 0 makes the output rise on the event edge itself.
- R6: With `sync_dis_i` = 1, a SYNC event has no effect. The output keeps its period and phase across the event.
- R7: With `half_step_i` = 1, `clk_o` lags the undelayed waveform by half a clock cycle. Each change moves to the falling clock edge after the rising edge at which the undelayed output changes.
- R8: A divide value of 0 or 1 selects bypass. The output toggles on every rising edge. An accepted event forces the output to 1 on edge E, and the delay counts are ignored.
- R9: A polarity-bit pulse of 0 then 1 then 0, with the pin held low, produces exactly one SYNC event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast distribution clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Divide ratio; 0 or 1 selects bypass |
| dly_hi_i | input | DLY_W | High part of the post-SYNC delay |
| dly_lo_i | input | DLY_W | Low part of the post-SYNC delay |
| half_step_i | input | 1 | Adds a half-cycle output lag |
| sync_dis_i | input | 1 | 1 makes the channel ignore SYNC |
| sync_pin_i | input | 1 | External SYNC request |
| sync_pol_i | input | 1 | Software polarity, XORed with the pin |
| clk_o | output | 1 | Divided device clock |

## Verification
Directed SYNC runs cover several patterns, and each one separates a different fault:
- Ratios 2 and 20 and the odd ratios 3 and 7 separate an exact period and duty cycle from off-by-one counts.
- Delays of 0, 1 and 5, together with swapped high/low pairs, show that the restart phase follows the sum of the two counts.
- Events raised through the pin and through the polarity bit, each followed by a falling edge during the check window, separate edge detection from level detection.
- Half-step runs separate a half-cycle lag from a whole-cycle shift.

Randomized ratios, delays and half-step settings then exercise the same phase formula. Disabled-channel runs use two different delays. They compare every sample with the sample one period earlier across a SYNC, so a channel that restarts anyway breaks the comparison.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  parameter int unsigned DIV_W_DEF  = 8;
  parameter int unsigned DLY_W_DEF  = 6;
  parameter int unsigned SYNC_N_DEF = 2;

  typedef enum logic [2:0] {
    ACT_RUN,
    ACT_HOLD,
    ACT_LOAD,
    ACT_SYNC_RUN,
    ACT_TOGGLE,
    ACT_BYP_SYNC
  } act_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic evt_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= raw_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[STAGES-2:0], raw_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sq[STAGES-1];

  assign evt_o = sq[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
  import clk_div_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF,
  parameter int unsigned DLY_W = DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_hi_i,
  input  logic [DLY_W-1:0] dly_lo_i,
  input  logic             start_i,
  output logic             q_o,
  output logic [DLY_W:0]   dly_o,
  output logic [DLY_W:0]   dtot_o
);
  localparam int unsigned CW = DIV_W + 1;
  localparam int unsigned DW = DLY_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DW-1:0]    dly_q;
  logic             q_q;
  logic             byp;
  logic [CW-1:0]    hi_len;
  logic [DW-1:0]    dtot;
  logic             wrap;
  act_e             act;

  assign byp    = (div_i <= DIV_W'(1));
  assign hi_len = ({1'b0, div_i} + CW'(1)) >> 1;
  assign dtot   = {1'b0, dly_hi_i} + {1'b0, dly_lo_i};
  // wrap also catches a count left out of range by a ratio change
  assign wrap   = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, div_i};

  always_comb begin
    if (start_i)            act = byp ? ACT_BYP_SYNC : ((dtot == '0) ? ACT_SYNC_RUN : ACT_LOAD);
    else if (byp)           act = ACT_TOGGLE;
    else if (dly_q != '0)   act = ACT_HOLD;
    else                    act = ACT_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dly_q <= '0;
      q_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_BYP_SYNC: begin q_q <= 1'b1; dly_q <= '0; cnt_q <= '0; end
        ACT_TOGGLE:   begin q_q <= ~q_q; dly_q <= '0; end
        ACT_SYNC_RUN: begin q_q <= 1'b1; dly_q <= '0; cnt_q <= DIV_W'(1); end
        ACT_LOAD:     begin q_q <= 1'b0; dly_q <= dtot - DW'(1); cnt_q <= '0; end
        ACT_HOLD:     begin q_q <= 1'b0; dly_q <= dly_q - DW'(1); end
        default: begin
          q_q   <= ({1'b0, cnt_q} < hi_len);
          cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
        end
      endcase
    end
  end

  assign q_o    = q_q;
  assign dly_o  = dly_q;
  assign dtot_o = dtot;
endmodule

// File: rtl/half_step_out.sv
module half_step_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q_i,
  input  logic half_i,
  output logic clk_o
);
  logic q_neg;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) q_neg <= 1'b0;
    else         q_neg <= q_i;

  assign clk_o = half_i ? q_neg : q_i;
endmodule

// File: rtl/sync_clk_div.sv
module sync_clk_div
  import clk_div_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned DLY_W  = DLY_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_hi_i,
  input  logic [DLY_W-1:0] dly_lo_i,
  input  logic             half_step_i,
  input  logic             sync_dis_i,
  input  logic             sync_pin_i,
  input  logic             sync_pol_i,
  output logic             clk_o
);
  logic           sync_evt;
  logic           start;
  logic           q_pos;
  logic [DLY_W:0] dly_cnt;
  logic [DLY_W:0] dly_tot;

  sync_edge_det #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (sync_pin_i ^ sync_pol_i),
    .evt_o (sync_evt)
  );

  assign start = sync_evt & ~sync_dis_i;

  clk_div_core #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .dly_hi_i(dly_hi_i),
    .dly_lo_i(dly_lo_i),
    .start_i (start),
    .q_o     (q_pos),
    .dly_o   (dly_cnt),
    .dtot_o  (dly_tot)
  );

  half_step_out u_hs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_i   (q_pos),
    .half_i(half_step_i),
    .clk_o (clk_o)
  );
endmodule

// File: rtl/sync_clk_div_chk.sv
module sync_clk_div_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DLY_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] div_i,
  input logic             sync_dis_i,
  input logic             clk_o,
  input logic             evt_i,
  input logic             q_i,
  input logic [DLY_W:0]   dly_i,
  input logic [DLY_W:0]   dtot_i
);
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_low: assert (clk_o == 1'b0);

  a_r3_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !evt_i);

  a_r6_disabled_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && sync_dis_i && dly_i == '0) |=> (dly_i == '0));

  a_r4_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !sync_dis_i && div_i > DIV_W'(1) && dtot_i != '0) |=> !q_i);

  a_r8_bypass_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i <= DIV_W'(1) && !(evt_i && !sync_dis_i)) |=> (q_i != $past(q_i)));
endmodule

bind sync_clk_div sync_clk_div_chk #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_i     (div_i),
  .sync_dis_i(sync_dis_i),
  .clk_o     (clk_o),
  .evt_i     (sync_evt),
  .q_i       (q_pos),
  .dly_i     (dly_cnt),
  .dtot_i    (dly_tot)
);

// File: tb/sync_clk_div_bench.sv
module sync_clk_div_bench;
  localparam int DIV_W = 8;
  localparam int DLY_W = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b1;
  logic [DIV_W-1:0] div_i = '0;
  logic [DLY_W-1:0] dly_hi_i = '0;
  logic [DLY_W-1:0] dly_lo_i = '0;
  logic             half_step_i = 1'b0;
  logic             sync_dis_i = 1'b0;
  logic             sync_pin_i = 1'b0;
  logic             sync_pol_i = 1'b0;
  logic             clk_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sync_clk_div #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_sync_clk_div (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  // expected undelayed output on edge E+j
  function automatic logic exp_q(int j, int n, int d);
    if (n < 2) return (j % 2) == 0;
    if (j < d) return 1'b0;
    return ((j - d) % n) < ((n + 1) / 2);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #1;
  endtask

  // raise the combined SYNC just after an edge, check from edge E on
  task automatic sync_run(int n, int hi, int lo, bit hs, bit use_pol, string req);
    int d = (n < 2) ? 0 : hi + lo;
    int len = d + 3 * ((n < 2) ? 2 : n) + 6;
    div_i = DIV_W'(n); dly_hi_i = DLY_W'(hi); dly_lo_i = DLY_W'(lo);
    half_step_i = hs; sync_dis_i = 1'b0;
    idle(3);
    if (use_pol) sync_pol_i = 1'b1; else sync_pin_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    for (int j = 0; j < len; j++) begin
      @(posedge clk_i); #1;
      if (!(hs && j == 0))
        chk(clk_o, hs ? exp_q(j - 1, n, d) : exp_q(j, n, d), req);
      if (j == 3) begin sync_pol_i = 1'b0; sync_pin_i = 1'b0; end  // R3 falling edge: no event
    end
  endtask

  // R6: disabled channel keeps period and phase across SYNC
  task automatic dis_run(int n, int hi, int lo);
    logic smp [0:127];
    div_i = DIV_W'(n); dly_hi_i = DLY_W'(hi); dly_lo_i = DLY_W'(lo);
    half_step_i = 1'b0; sync_dis_i = 1'b1;
    idle(3 * n + 4);
    for (int t = 0; t < 4 * n + 12; t++) begin
      @(posedge clk_i); #1;
      smp[t] = clk_o;
      if (t == 4)  sync_pin_i = 1'b1;
      if (t == 10) sync_pin_i = 1'b0;
    end
    for (int t = n; t < 4 * n + 12; t++) chk(smp[t], smp[t - n], "R6");
    sync_dis_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd731));
    #1 rst_ni = 1'b0;
    div_i = 8'd4; half_step_i = 1'b1; sync_pin_i = 1'b1;
    for (int i = 0; i < 4; i++) begin @(posedge clk_i); #1; chk(clk_o, 1'b0, "R1"); end
    sync_pin_i = 1'b0; half_step_i = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(4);

    sync_run(2, 0, 0, 0, 0, "R2/R5 N=2 D=0");
    sync_run(20, 2, 3, 0, 1, "R2/R4/R9 N=20 D=5 pol");
    sync_run(3, 1, 0, 0, 0, "R2/R4 N=3 D=1");
    sync_run(7, 0, 1, 0, 1, "R2/R4 N=7 D=1 pol");
    sync_run(6, 4, 1, 0, 0, "R5 hi=4 lo=1");
    sync_run(6, 1, 4, 0, 0, "R5 hi=1 lo=4");
    sync_run(3, 0, 2, 1, 0, "R7 N=3 half step");
    sync_run(1, 3, 4, 0, 0, "R8 bypass N=1");
    sync_run(0, 5, 0, 1, 1, "R8/R7 bypass N=0");
    sync_run(20, 63, 63, 0, 0, "R4 max delay");

    for (int k = 0; k < 10; k++) begin
      int n  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 1) : $urandom_range(2, 40);
      int hi = $urandom_range(0, 15);
      int lo = $urandom_range(0, 15);
      bit hs = 1'($urandom_range(0, 1));
      bit up = 1'($urandom_range(0, 1));
      sync_run(n, hi, lo, hs, up, "R2/R4 random");
    end

    dis_run(6, 2, 1);
    dis_run(6, 1, 3);
    dis_run(11, 0, 4);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule